// File: doc/BRIEF.md
# Synchronous Trap Priority Arbiter with Execute-Trigger Timing

This block sits at the retire stage of a processor pipeline. For each retiring instruction it decides which synchronous trap, if any, is taken. It weighs an instruction-address execute trigger against an illegal-instruction exception and against an after-timed trigger left over from the previous retire. When a trap is taken it produces the cause code, the exception PC, and the fetch redirect to the trap vector. It also updates the machine interrupt-enable bit.

A before-timed trigger is judged on its own instruction, before that instruction executes. An after-timed trigger is stored in a single one-cycle flag and judged on the next retiring instruction. No pending state is kept for it. If traps are disabled when that next instruction retires, the hit is discarded for good. This case matters when the instruction that raised the hit was illegal: the following instruction is then the first instruction of the handler, where the enable bit has just been cleared.

The bit that allows triggers to trap is chosen at build time. By default it is the interrupt-enable bit the block holds. When `GATE_ALT` is 1, a separate trigger-enable input takes over that role.

Top module: `sync_trap_arbiter`

## Requirements
- R1: A before-timed trigger hit on a retiring instruction, with the gate bit at 1, takes a trap one cycle later with cause 3 and epc equal to that instruction's PC. It wins over a simultaneous illegal flag.
- R2: An illegal retiring instruction without an enabled before-timed hit takes a trap with cause 2 and epc equal to its own PC. It wins over a carried after-timed hit.
- R3: An after-timed hit is carried to the next retire. If the gate bit is 1 there and nothing of higher rank fires, a trap is taken with cause 3 and epc equal to that next instruction's PC.
- R4: A carried after-timed hit that meets a gate bit of 0 is dropped. No trap results from it later, even after the gate bit returns to 1. A before-timed hit with the gate bit at 0 also takes no trap.
- R5: The carry flag is rewritten on every retire. It is loaded from the after-timed hit unless a trigger trap is taken on that same instruction. A hit raised by an illegal instruction is still carried.
- R6: A trap sets MPIE to the old MIE and clears MIE. A retiring return instruction with no trap restores MIE from MPIE and sets MPIE to 1. Otherwise a write strobe loads MIE. A trap takes precedence over a return, and a return over a write.
- R7: On each retire, `npc_o` becomes `mtvec_base` if a trap is taken and `retire_npc` if not. Without a retire it holds its value.
- R8: `trap_o` is a registered one-cycle strobe. It is high only in the cycle after a retire that took a trap.
- R9: The synchronous active-high reset clears `trap_o`, `cause_o`, `epc_o`, `npc_o`, MIE, MPIE and the carry flag.
- R10: With `GATE_ALT`=1, `alt_trig_en` replaces MIE as the gate for both trigger timings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_pc | input | XLEN | PC of the retiring instruction |
| retire_npc | input | XLEN | Next-sequential or target PC when no trap is taken |
| retire_illegal | input | 1 | Retiring instruction is illegal |
| trig_before_hit | input | 1 | Before-timed execute trigger matched this instruction |
| trig_after_hit | input | 1 | After-timed execute trigger matched this instruction |
| retire_mret | input | 1 | Retiring instruction is a trap return |
| mtvec_base | input | XLEN | Trap vector address |
| mie_wr_en | input | 1 | Software write strobe for MIE |
| mie_wr_val | input | 1 | Value for the MIE write |
| alt_trig_en | input | 1 | Alternative trigger-enable bit (used when GATE_ALT=1) |
| trap_o | output | 1 | Trap taken strobe |
| cause_o | output | CAUSE_W | Cause code: 2 illegal, 3 breakpoint |
| epc_o | output | XLEN | Value to write to the exception PC register |
| npc_o | output | XLEN | Next fetch address (trap vector on a trap) |
| mie_o | output | 1 | Current MIE |

## Verification
The checker module tests the following on every cycle:
- before-timed priority and its epc;
- illegal-instruction priority whenever no enabled before-timed hit is present;
- the cleared MIE after every trap;
- the redirect to the trap vector;
- the hold of outputs on idle cycles;
- the absence of trigger traps while the gate bit is 0.

Some effects depend on history across instructions, and only the bench scenarios show them:
- the carry of an after-timed hit, and whether it is taken or lost on the next retire;
- its permanent loss when the handler's first instruction sees MIE at 0;
- the MIE restore by a return instruction;
- the alternative gate variant.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_ILL   = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_BREAK = 4'd3;

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_BEFORE  = 2'd1,
    SEL_ILLEGAL = 2'd2,
    SEL_AFTER   = 2'd3
  } trap_sel_e;
endpackage

// File: rtl/trp_gate.sv
module trp_gate #(
  parameter bit GATE_ALT = 1'b0
) (
  input  logic mie,
  input  logic alt_en,
  output logic gate
);
  // Build-time choice of the bit that allows triggers to trap
  assign gate = GATE_ALT ? alt_en : mie;
endmodule

// File: rtl/trp_prio.sv
module trp_prio
  import trp_pkg::*;
(
  input  logic      valid,
  input  logic      gate,
  input  logic      before_hit,
  input  logic      illegal,
  input  logic      after_pend,
  output trap_sel_e sel
);
  // Rank: enabled before-trigger, then illegal, then carried after-trigger
  always_comb begin
    sel = SEL_NONE;
    if (valid) begin
      if (before_hit && gate)      sel = SEL_BEFORE;
      else if (illegal)            sel = SEL_ILLEGAL;
      else if (after_pend && gate) sel = SEL_AFTER;
    end
  end
endmodule

// File: rtl/trp_carry.sv
module trp_carry (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic load_hit,
  output logic pend
);
  // One-cycle carry of an after-timed hit; rewritten on every retire
  always_ff @(posedge clk) begin
    if (rst)        pend <= 1'b0;
    else if (valid) pend <= load_hit;
  end
endmodule

// File: rtl/trp_status.sv
module trp_status (
  input  logic clk,
  input  logic rst,
  input  logic trap_take,
  input  logic ret_take,
  input  logic wr_en,
  input  logic wr_val,
  output logic mie
);
  logic mpie;

  always_ff @(posedge clk) begin
    if (rst) begin
      mie  <= 1'b0;
      mpie <= 1'b0;
    end else if (trap_take) begin
      mpie <= mie;
      mie  <= 1'b0;
    end else if (ret_take) begin
      mie  <= mpie;
      mpie <= 1'b1;
    end else if (wr_en) begin
      mie  <= wr_val;
    end
  end
endmodule

// File: rtl/sync_trap_arbiter.sv
module sync_trap_arbiter
  import trp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter bit GATE_ALT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               retire_valid,
  input  logic [XLEN-1:0]    retire_pc,
  input  logic [XLEN-1:0]    retire_npc,
  input  logic               retire_illegal,
  input  logic               trig_before_hit,
  input  logic               trig_after_hit,
  input  logic               retire_mret,
  input  logic [XLEN-1:0]    mtvec_base,
  input  logic               mie_wr_en,
  input  logic               mie_wr_val,
  input  logic               alt_trig_en,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    npc_o,
  output logic               mie_o
);
  logic      gate;
  logic      after_pend;
  logic      take;
  logic      trig_take;
  trap_sel_e sel;

  trp_gate #(.GATE_ALT(GATE_ALT)) u_gate (
    .mie    (mie_o),
    .alt_en (alt_trig_en),
    .gate   (gate)
  );

  trp_prio u_prio (
    .valid      (retire_valid),
    .gate       (gate),
    .before_hit (trig_before_hit),
    .illegal    (retire_illegal),
    .after_pend (after_pend),
    .sel        (sel)
  );

  assign take      = (sel != SEL_NONE);
  assign trig_take = (sel == SEL_BEFORE) || (sel == SEL_AFTER);

  // An instruction stopped by a trigger trap never executes, so it raises no after-hit
  trp_carry u_carry (
    .clk      (clk),
    .rst      (rst),
    .valid    (retire_valid),
    .load_hit (trig_after_hit && !trig_take),
    .pend     (after_pend)
  );

  trp_status u_status (
    .clk       (clk),
    .rst       (rst),
    .trap_take (take),
    .ret_take  (retire_valid && retire_mret && !take),
    .wr_en     (mie_wr_en),
    .wr_val    (mie_wr_val),
    .mie       (mie_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o  <= 1'b0;
      cause_o <= '0;
      epc_o   <= '0;
      npc_o   <= '0;
    end else begin
      trap_o <= take;
      if (take) begin
        cause_o <= (sel == SEL_ILLEGAL) ? CAUSE_ILL : CAUSE_BREAK;
        epc_o   <= retire_pc;
      end
      if (retire_valid) npc_o <= take ? mtvec_base : retire_npc;
    end
  end
endmodule

// File: rtl/trp_chk.sv
module trp_chk
  import trp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter bit GATE_ALT = 1'b0
) (
  input logic               clk,
  input logic               rst,
  input logic               retire_valid,
  input logic [XLEN-1:0]    retire_pc,
  input logic [XLEN-1:0]    retire_npc,
  input logic               retire_illegal,
  input logic               trig_before_hit,
  input logic [XLEN-1:0]    mtvec_base,
  input logic               mie_wr_en,
  input logic               mie_wr_val,
  input logic               alt_trig_en,
  input logic               trap_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [XLEN-1:0]    epc_o,
  input logic [XLEN-1:0]    npc_o,
  input logic               mie_o
);
  logic gate_seen;
  assign gate_seen = GATE_ALT ? alt_trig_en : mie_o;

  // R1
  before_wins_chk: assert property (@(posedge clk) disable iff (rst)
    retire_valid && trig_before_hit && gate_seen
    |=> trap_o && cause_o == CAUSE_BREAK && epc_o == $past(retire_pc));

  // R2
  illegal_rank_chk: assert property (@(posedge clk) disable iff (rst)
    retire_valid && retire_illegal && !(trig_before_hit && gate_seen)
    |=> trap_o && cause_o == CAUSE_ILL && epc_o == $past(retire_pc));

  // R4
  gated_off_chk: assert property (@(posedge clk) disable iff (rst)
    retire_valid && !gate_seen && !retire_illegal |=> !trap_o);

  // R6
  trap_clears_mie_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> !mie_o);

  // R6
  mie_write_chk: assert property (@(posedge clk) disable iff (rst)
    mie_wr_en && !retire_valid |=> mie_o == $past(mie_wr_val));

  // R7
  vector_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> npc_o == $past(mtvec_base));

  // R7
  seq_npc_chk: assert property (@(posedge clk) disable iff (rst)
    retire_valid |=> trap_o || npc_o == $past(retire_npc));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !retire_valid |=> !trap_o && $stable(npc_o));
endmodule

bind sync_trap_arbiter trp_chk #(.XLEN(XLEN), .GATE_ALT(GATE_ALT)) u_chk (.*);

// File: tb/sim_sync_trap_arbiter.sv
`timescale 1ns/1ps
module sim_sync_trap_arbiter;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] VEC = 32'h0000_0800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic retire_valid = 0, retire_illegal = 0, trig_before_hit = 0, trig_after_hit = 0;
  logic retire_mret = 0, mie_wr_en = 0, mie_wr_val = 0, alt_trig_en = 0;
  logic [XLEN-1:0] retire_pc = '0, retire_npc = '0;
  logic [XLEN-1:0] mtvec_base = VEC;
  logic trap0, trap1, mie0, mie1;
  logic [3:0] cause0, cause1;
  logic [XLEN-1:0] epc0, epc1, npc0, npc1;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  sync_trap_arbiter #(.XLEN(XLEN), .GATE_ALT(1'b0)) u0 (
    .clk, .rst, .retire_valid, .retire_pc, .retire_npc, .retire_illegal,
    .trig_before_hit, .trig_after_hit, .retire_mret, .mtvec_base,
    .mie_wr_en, .mie_wr_val, .alt_trig_en,
    .trap_o(trap0), .cause_o(cause0), .epc_o(epc0), .npc_o(npc0), .mie_o(mie0));

  sync_trap_arbiter #(.XLEN(XLEN), .GATE_ALT(1'b1)) u1 (
    .clk, .rst, .retire_valid, .retire_pc, .retire_npc, .retire_illegal,
    .trig_before_hit, .trig_after_hit, .retire_mret, .mtvec_base,
    .mie_wr_en, .mie_wr_val, .alt_trig_en,
    .trap_o(trap1), .cause_o(cause1), .epc_o(epc1), .npc_o(npc1), .mie_o(mie1));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One retire; outputs are sampled at the following falling edge
  task automatic retire(input logic [XLEN-1:0] pc, input logic ill, input logic tb,
                        input logic ta, input logic mret);
    retire_valid = 1; retire_pc = pc; retire_npc = pc + 4;
    retire_illegal = ill; trig_before_hit = tb; trig_after_hit = ta; retire_mret = mret;
    @(negedge clk);
    retire_valid = 0; retire_illegal = 0; trig_before_hit = 0;
    trig_after_hit = 0; retire_mret = 0;
  endtask

  task automatic set_mie(input logic v);
    mie_wr_en = 1; mie_wr_val = v;
    @(negedge clk);
    mie_wr_en = 0;
  endtask

  task automatic t_reset;
    chk("R9 trap after reset", trap0, 0);
    chk("R9 mie after reset", mie0, 0);
    chk("R9 npc after reset", npc0, 0);
    set_mie(1);
    chk("R6 mie write", mie0, 1);
  endtask

  task automatic t_before_vs_illegal;
    retire(32'h100, 1, 1, 0, 0);
    chk("R1 trap", trap0, 1);
    chk("R1 cause", cause0, 3);
    chk("R1 epc", epc0, 32'h100);
    chk("R7 vector", npc0, VEC);
    chk("R6 mie cleared", mie0, 0);
    @(negedge clk);
    chk("R8 strobe one cycle", trap0, 0);
  endtask

  task automatic t_after_vs_illegal_lost;
    set_mie(1);
    retire(32'h200, 1, 0, 1, 0);
    chk("R2 trap", trap0, 1);
    chk("R2 cause", cause0, 2);
    chk("R2 epc", epc0, 32'h200);
    retire(VEC, 0, 0, 0, 0);
    chk("R4 hit lost in handler", trap0, 0);
    chk("R7 sequential npc", npc0, VEC + 4);
    set_mie(1);
    retire(VEC + 4, 0, 0, 0, 0);
    chk("R5 no late trap", trap0, 0);
  endtask

  task automatic t_after_taken;
    retire(32'h300, 0, 0, 1, 0);
    chk("R3 no trap on own instr", trap0, 0);
    retire(32'h304, 0, 0, 0, 0);
    chk("R3 trap", trap0, 1);
    chk("R3 cause", cause0, 3);
    chk("R3 epc next instr", epc0, 32'h304);
    retire(VEC, 0, 0, 0, 1);
    chk("R6 return restores mie", mie0, 1);
    chk("R8 no trap on return", trap0, 0);
  endtask

  task automatic t_after_lost_mie0;
    set_mie(0);
    retire(32'h400, 0, 0, 1, 0);
    retire(32'h404, 0, 0, 0, 0);
    chk("R4 dropped at mie 0", trap0, 0);
    set_mie(1);
    retire(32'h408, 0, 0, 0, 0);
    chk("R4 stays dropped", trap0, 0);
    retire(32'h40c, 0, 1, 0, 0);
    chk("R1 before with mie 1", trap0, 1);
  endtask

  task automatic t_carry_vs_illegal;
    set_mie(1);
    retire(32'h500, 0, 0, 1, 0);
    retire(32'h504, 1, 0, 0, 0);
    chk("R2 illegal beats carried", cause0, 2);
    chk("R2 epc", epc0, 32'h504);
    set_mie(1);
    retire(32'h508, 0, 0, 0, 0);
    chk("R5 carry cleared", trap0, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    chk("R8 idle no trap", trap0, 0);
    chk("R7 idle holds npc", npc0, 32'h50c);
  endtask

  task automatic t_alt_gate;
    set_mie(0);
    alt_trig_en = 1;
    retire(32'h600, 0, 1, 0, 0);
    chk("R10 alt gate traps", trap1, 1);
    chk("R4 mie 0 blocks default", trap0, 0);
    alt_trig_en = 0;
    set_mie(1);
    retire(32'h604, 0, 1, 0, 0);
    chk("R10 alt 0 blocks", trap1, 0);
    chk("R1 default traps", trap0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_before_vs_illegal();
    t_after_vs_illegal_lost();
    t_after_taken();
    t_after_lost_mie0();
    t_carry_vs_illegal();
    t_idle();
    t_alt_gate();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule